// File: doc/BRIEF.md
# Clock Source Switch Controller

This block manages run-time selection of the system clock among four oscillators: a primary crystal or external input, a low-power crystal, a fast internal RC and a low-power internal RC. The two faster sources can also be used through the PLL. Software changes the source through two protected register bytes. The upper byte holds the requested source. The lower byte holds the switch-request bit and a bit that keeps the low-power crystal running. Each protected write must come in the cycle right after a two-byte unlock sequence written to a key address.

Once a request is accepted, the controller rejects redundant or forbidden targets. For a valid target it clears the PLL-lock and clock-fail flags, turns on the target oscillator and PLL, and waits for crystal start-up and PLL lock as the target needs. It then counts a fixed number of cycles of the new clock and hands the system over. The analog oscillators and the PLL appear as enable/ready pairs, and each source's clock appears as a one-cycle tick input in the controller's domain. A configuration input can disable switching altogether. While it is low, the status shows the configured start-up source.

Top module: `clk_switch_ctl`

## Requirements
- R1: Source codes are 3 bits: 0 fast RC, 1 fast RC with PLL, 2 primary, 3 primary with PLL, 4 low-power crystal, 5 low-power RC. The oscillator bit index is 0 fast RC, 1 primary, 2 low-power crystal, 3 low-power RC.
- R2: While `cfg_sw_en` is low, `sw_req` stays 0 and protected writes to the requested-source byte are discarded.
- R3: Out of reset, and at any time while `cfg_sw_en` is low, `cur_src` equals `cfg_start_src`.
- R4: A protected write is accepted only when two earlier bus cycles wrote key 0x46 and then key 0x57 to address 2 on consecutive clock cycles, and the write comes in the very next cycle. Address 1 is the requested-source byte (bits 2:0). Address 0 is the control byte (bit 0 starts a switch, bit 1 keeps the low-power crystal on). Any other write is ignored.
- R5: A request whose target equals the current source clears `sw_req` on its own. `cur_src` and the status flags stay unchanged.
- R6: `lock_st` is set while the PLL is enabled and locked. `fail_st` is set by a `clk_fail` pulse. A valid switch start clears both flags.
- R7: A crystal target (codes 2, 3, 4) waits for its `osc_ready` bit. A PLL target (codes 1, 3) waits for `pll_lock`. No handover happens before these are present.
- R8: After the target is ready, the handover follows the 10th tick of the target's `src_tick` bit and not before.
- R9: At handover `sw_req` clears and `cur_src` takes the requested code.
- R10: Outside a switch, `osc_en` holds only the current source's bit. The low-power RC bit is added when `cfg_wdt_en` is high, and the low-power crystal bit is added when the keep bit is set.
- R11: A request between codes 1 and 3, in either direction, and any request for code 6 or 7, is rejected. `sw_req` clears and `cur_src` is unchanged.
- R12: While `sw_req` is set, writes to the requested-source byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sw_en | input | 1 | Configuration: switching allowed |
| cfg_start_src | input | 3 | Configuration: start-up source code |
| cfg_wdt_en | input | 1 | Watchdog or fail-safe monitor enabled |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | 0 control byte, 1 requested source, 2 key |
| bus_wdata | input | 8 | Bus write data |
| osc_ready | input | 4 | Crystal start-up timer expired, per oscillator |
| pll_lock | input | 1 | PLL locked |
| src_tick | input | 4 | One pulse per cycle of each oscillator |
| clk_fail | input | 1 | Clock failure event pulse |
| osc_en | output | 4 | Oscillator enables |
| pll_en | output | 1 | PLL enable |
| cur_src | output | 3 | Current source status |
| req_src | output | 3 | Requested source field |
| sw_req | output | 1 | Switch request pending |
| keep_lpx | output | 1 | Keep low-power crystal running |
| lock_st | output | 1 | PLL-lock status flag |
| fail_st | output | 1 | Clock-fail status flag |

## Verification
The assertions assume a reset at time zero. They also assume that `src_tick` and the ready inputs are clean single-bit levels in the controller clock domain, and that `cfg_sw_en` does not change in the middle of a switch. The bench keeps to these limits: it applies every input on the falling edge, produces oscillator ready and PLL lock from registered copies of the enables gated by masks, and changes the configuration only while no switch is pending. The random phase draws request codes over the full 3-bit range, and its ticks are random bits.

// File: rtl/clk_switch_ctl.sv
module clk_switch_ctl #(
  parameter int SETTLE_N = 10,
  parameter logic [7:0] KEY_A = 8'h46,
  parameter logic [7:0] KEY_B = 8'h57
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sw_en,
  input  logic [2:0] cfg_start_src,
  input  logic       cfg_wdt_en,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic [3:0] osc_ready,
  input  logic       pll_lock,
  input  logic [3:0] src_tick,
  input  logic       clk_fail,
  output logic [3:0] osc_en,
  output logic       pll_en,
  output logic [2:0] cur_src,
  output logic [2:0] req_src,
  output logic       sw_req,
  output logic       keep_lpx,
  output logic       lock_st,
  output logic       fail_st
);
  localparam int CW = $clog2(SETTLE_N + 1);

  typedef enum logic [1:0] {IDLE, WAIT_RDY, SETTLE} st_t;

  function automatic logic [1:0] phys(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: phys = 2'd0;
      3'd2, 3'd3: phys = 2'd1;
      3'd4:       phys = 2'd2;
      default:    phys = 2'd3;
    endcase
  endfunction

  function automatic logic uses_pll(input logic [2:0] c);
    uses_pll = (c == 3'd1) || (c == 3'd3);
  endfunction

  function automatic logic is_xtal(input logic [2:0] c);
    is_xtal = (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
  endfunction

  st_t        st;
  logic [1:0] key_st;
  logic [2:0] cur_q, req_q;
  logic [CW-1:0] cnt;
  logic       sw_q;

  wire armed   = key_st == 2'd2;
  wire wr_lo   = bus_we && armed && bus_addr == 2'd0;
  wire wr_hi   = bus_we && armed && bus_addr == 2'd1;
  wire key_hit = bus_we && bus_addr == 2'd2;
  wire busy    = st != IDLE;
  wire redund  = req_q == cur_q;
  wire bad     = req_q > 3'd5 || (cur_q == 3'd1 && req_q == 3'd3) || (cur_q == 3'd3 && req_q == 3'd1);
  wire start   = st == IDLE && sw_q && !redund && !bad;
  wire ready   = (!is_xtal(req_q) || osc_ready[phys(req_q)]) && (!uses_pll(req_q) || pll_lock);
  wire tick    = src_tick[phys(req_q)];

  assign cur_src = cfg_sw_en ? cur_q : cfg_start_src;
  assign req_src = req_q;
  assign sw_req  = sw_q;
  assign pll_en  = uses_pll(cur_q) || (busy && uses_pll(req_q));

  always_comb begin
    for (int s = 0; s < 4; s++)
      osc_en[s] = phys(cur_q) == 2'(s) || (busy && phys(req_q) == 2'(s)) ||
                  (s == 3 && cfg_wdt_en) || (s == 2 && keep_lpx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; key_st <= 2'd0; sw_q <= 1'b0; cnt <= '0;
      cur_q <= cfg_start_src; req_q <= cfg_start_src;
      keep_lpx <= 1'b0; lock_st <= 1'b0; fail_st <= 1'b0;
    end else begin
      if (key_hit && bus_wdata == KEY_A)                     key_st <= 2'd1;
      else if (key_st == 2'd1 && key_hit && bus_wdata == KEY_B) key_st <= 2'd2;
      else                                                   key_st <= 2'd0;

      if (wr_lo) keep_lpx <= bus_wdata[1];

      if (!cfg_sw_en) begin
        st <= IDLE; sw_q <= 1'b0; cnt <= '0; cur_q <= cfg_start_src;
      end else begin
        if (wr_hi && !sw_q) req_q <= bus_wdata[2:0];
        case (st)
          IDLE: begin
            if (sw_q) begin
              if (start) st <= WAIT_RDY;
              else       sw_q <= 1'b0;
            end else if (wr_lo && bus_wdata[0]) sw_q <= 1'b1;
          end
          WAIT_RDY: if (ready) begin st <= SETTLE; cnt <= '0; end
          SETTLE: if (tick) begin
            if (cnt == CW'(SETTLE_N - 1)) begin
              cur_q <= req_q; sw_q <= 1'b0; st <= IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= IDLE;
        endcase
      end

      if (start)                  lock_st <= 1'b0;
      else if (pll_en && pll_lock) lock_st <= 1'b1;
      if (start)         fail_st <= 1'b0;
      else if (clk_fail) fail_st <= 1'b1;
    end
  end

  assert_disabled_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sw_en |=> !sw_q);
  assert_req_needs_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_q) |-> $past(armed && bus_we && bus_addr == 2'd0));
  assert_redundant_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_en && st == IDLE && sw_q && redund) |=> (!sw_q && (cur_q == $past(cur_q) || !cfg_sw_en)));
  assert_start_clears_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!lock_st && !fail_st));
  assert_handover_after_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_en && $past(cfg_sw_en) && cur_q != $past(cur_q)) |-> $past(st == SETTLE && tick));
  assert_no_pll_cross_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_en && $past(cfg_sw_en)) |->
      !(($past(cur_q) == 3'd1 && cur_q == 3'd3) || ($past(cur_q) == 3'd3 && cur_q == 3'd1)));
  assert_req_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q && cfg_sw_en) |=> (req_q == $past(req_q)));
endmodule

// File: tb/sim_clk_switch_ctl.sv
module sim_clk_switch_ctl;
  logic clk = 0, rst_n = 0;
  logic cfg_sw_en = 1, cfg_wdt_en = 0;
  logic [2:0] cfg_start_src = 3'd2;
  logic bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [3:0] osc_ready = 0, src_tick, tick_man = 0, tick_rnd = 0, rdy_allow = 4'hF;
  logic pll_lock = 0, pll_allow = 1, clk_fail = 0, tick_auto = 0;
  logic [3:0] osc_en;
  logic pll_en, sw_req, keep_lpx, lock_st, fail_st;
  logic [2:0] cur_src, req_src;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign src_tick = tick_auto ? tick_rnd : tick_man;
  always @(posedge clk) begin
    osc_ready <= osc_en & rdy_allow;
    pll_lock  <= pll_en & pll_allow;
  end
  always @(negedge clk) tick_rnd <= 4'($urandom);

  clk_switch_ctl u0 (.clk, .rst_n, .cfg_sw_en, .cfg_start_src, .cfg_wdt_en, .bus_we, .bus_addr,
    .bus_wdata, .osc_ready, .pll_lock, .src_tick, .clk_fail, .osc_en, .pll_en, .cur_src,
    .req_src, .sw_req, .keep_lpx, .lock_st, .fail_st);

  function automatic logic [1:0] phys(input logic [2:0] c);
    return (c < 2) ? 2'd0 : (c < 4) ? 2'd1 : (c == 4) ? 2'd2 : 2'd3;
  endfunction
  function automatic logic [2:0] exp_next(input logic [2:0] cur, input logic [2:0] rq);
    if (rq > 5 || rq == cur || (cur == 1 && rq == 3) || (cur == 3 && rq == 1)) return cur;
    return rq;
  endfunction
  function automatic logic [3:0] exp_en(input logic [2:0] cur, input logic wdt, input logic keep);
    logic [3:0] e = 4'b0001 << phys(cur);
    if (wdt) e[3] = 1'b1;
    if (keep) e[2] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask
  task automatic idle(input int n);
    @(negedge clk); bus_we = 0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask
  task automatic pwrite(input logic [1:0] a, input logic [7:0] d);
    bw(2'd2, 8'h46); bw(2'd2, 8'h57); bw(a, d); idle(1);
  endtask
  task automatic request(input logic [2:0] code, input logic keep);
    pwrite(2'd1, {5'd0, code}); pwrite(2'd0, {6'd0, keep, 1'b1});
  endtask
  task automatic wait_done();
    for (int i = 0; i < 400 && sw_req; i++) @(negedge clk);
  endtask
  task automatic pulse_tick(input logic [3:0] m);
    @(negedge clk); tick_man = m; @(negedge clk); tick_man = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] mcur, code;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset cur", cur_src, 2);
    chk("R9 reset sw_req", sw_req, 0);
    chk("R10 reset osc_en", osc_en, 4'b0010);
    chk("R10 reset pll_en", pll_en, 0);

    @(negedge clk); clk_fail = 1; @(negedge clk); clk_fail = 0;
    chk("R6 fail flag set", fail_st, 1);

    request(3'd2, 0); idle(2);
    chk("R5 redundant sw_req", sw_req, 0);
    chk("R5 redundant cur", cur_src, 2);
    chk("R5 redundant flag kept", fail_st, 1);

    bw(2'd1, 8'd0); idle(1);
    chk("R4 unkeyed high byte", req_src, 2);
    bw(2'd2, 8'h46); bw(2'd2, 8'h57); idle(1); bw(2'd0, 8'd1); idle(2);
    chk("R4 gap breaks unlock", sw_req, 0);
    bw(2'd2, 8'h57); bw(2'd2, 8'h46); bw(2'd0, 8'd1); idle(2);
    chk("R4 keys out of order", sw_req, 0);

    request(3'd0, 0); idle(4);
    chk("R6 start clears fail", fail_st, 0);
    pulse_tick(4'b0010);
    for (int i = 0; i < 9; i++) pulse_tick(4'b0001);
    chk("R8 nine ticks pending", sw_req, 1);
    chk("R8 nine ticks cur", cur_src, 2);
    pulse_tick(4'b0001);
    chk("R9 tenth tick sw_req", sw_req, 0);
    chk("R9 tenth tick cur", cur_src, 0);
    chk("R10 old source off", osc_en, 4'b0001);

    tick_auto = 1; rdy_allow = 4'b1101; pll_allow = 0;
    request(3'd3, 0); idle(40);
    chk("R7 crystal wait", sw_req, 1);
    chk("R7 crystal wait cur", cur_src, 0);
    pwrite(2'd1, 8'd5);
    chk("R12 req frozen", req_src, 3);
    rdy_allow = 4'hF; idle(40);
    chk("R7 pll wait", sw_req, 1);
    pll_allow = 1; wait_done(); idle(1);
    chk("R9 pll switch cur", cur_src, 3);
    chk("R6 lock flag", lock_st, 1);

    request(3'd1, 0); idle(3);
    chk("R11 cross rejected sw_req", sw_req, 0);
    chk("R11 cross rejected cur", cur_src, 3);
    request(3'd7, 0); idle(3);
    chk("R11 code 7 rejected", cur_src, 3);
    request(3'd0, 0); wait_done(); request(3'd1, 0); wait_done(); idle(1);
    chk("R1 via fast RC", cur_src, 1);

    cfg_wdt_en = 1;
    request(3'd2, 1); wait_done(); idle(1);
    chk("R10 keep and wdt", osc_en, 4'b1110);
    chk("R4 keep bit", keep_lpx, 1);
    cfg_wdt_en = 0; pwrite(2'd0, 8'd0); idle(1);
    chk("R10 only current", osc_en, 4'b0010);

    cfg_sw_en = 0; cfg_start_src = 3'd4; @(negedge clk);
    chk("R3 disabled status", cur_src, 4);
    request(3'd0, 0); idle(3);
    chk("R2 disabled sw_req", sw_req, 0);
    chk("R2 disabled req ignored", req_src, 2);
    cfg_sw_en = 1; idle(2);
    mcur = 3'd4;
    cfg_wdt_en = 1'($urandom);

    for (int it = 0; it < 150; it++) begin
      code = 3'($urandom);
      request(code, 0); wait_done(); idle(1);
      mcur = exp_next(mcur, code);
      chk("R9 random cur", cur_src, mcur);
      chk("R10 random osc_en", osc_en, exp_en(mcur, cfg_wdt_en, 0));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule